// File: doc/BRIEF.md
# Framed Serial Transmitter

This block turns bytes into an asynchronous serial stream whose character format comes from a control byte. The format covers word length, stop-bit length, parity on or off, parity sense, a fixed ("stick") parity bit, and a break that forces the line low. A baud enable pulses once per oversample period, at 16 pulses per bit. The block counts these pulses to time every bit it sends.

Bytes arrive on a valid/ready stream into a one-entry holding register. `in_ready` is high exactly when that register is empty. A byte is taken on any clock edge where `in_valid` and `in_ready` are both high. While the register is full, the producer must hold `in_valid` and `in_data` steady. The holding register passes its byte to the shifter as soon as the shifter is idle, or in the same cycle that the previous stop period ends, so characters can follow one another with no idle gap.

Control byte fields:

| Bits | Field | Meaning |
|---|---|---|
| 1:0 | word length | 00 = 5, 01 = 6, 10 = 7, 11 = 8 data bits |
| 2 | long stop | 1 = longer stop period |
| 3 | parity on | 1 = send a parity bit |
| 4 | parity sense | 1 = even, 0 = odd |
| 5 | stick parity | 1 = fixed parity bit |
| 6 | break | 1 = force the line low |
| 7 | unused | ignored |

Top module: `uart_fmt_tx`

## Requirements
- R1: Each character starts with a low start bit. The data bits follow LSB first. Every bit lasts exactly 16 `baud_tick` pulses, and no progress is made in cycles without a tick. Control bits 1:0 set the count of data bits as given in the table above. Data bits above the word length are not sent.
- R2: With control bit 2 = 0 the stop period is 16 ticks. With bit 2 = 1 it is 24 ticks for a 5-bit word and 32 ticks for 6, 7 or 8-bit words. The line is high throughout the stop period.
- R3: With control bit 3 = 1, one parity bit of 16 ticks is sent after the last data bit and before the stop period. With bit 3 = 0 no parity slot exists, and the stop period follows the last data bit directly.
- R4: With parity on and stick off, control bit 4 = 1 makes the count of ones in the sent data bits plus the parity bit even. Bit 4 = 0 makes that count odd. Only the data bits actually sent are counted.
- R5: With parity on and control bit 5 = 1, the parity bit is the inverse of bit 4, whatever the data. Bit 5 has no effect when parity is off.
- R6: While control bit 6 = 1, `txd` is low. The character timing is not changed, so `tx_empty` rises at the same cycle it would without the break.
- R7: `hold_empty` is high when the holding register holds no byte. `tx_empty` is high only when the holding register and the shifter are both idle.
- R8: `in_ready` equals the empty state of the holding register, and a byte is accepted only when `in_valid` and `in_ready` are both high. A byte waiting in the holding register starts right after the previous stop period, with no idle cycle in between.
- R9: The format (control bits 5:0) is captured when a byte enters the shifter. Changing those bits mid-character does not alter the character in flight.
- R10: Reset is asynchronous and active low. While reset is active and after it, `txd` is high (idle), `hold_empty`, `tx_empty` and `in_ready` are high, and a character in flight is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Oversample enable, 16 per bit |
| lcr_i | input | 8 | Character format control byte |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Holding register can take a byte |
| txd | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding register is empty |
| tx_empty | output | 1 | Holding register and shifter are both idle |

## Verification
The bench targets these corner cases:

- **Half stop bit.** It measures the 1.5-stop case with 5-bit words. A shifter that rounds it to one or two bits ends 8 ticks early or late.
- **Parity over masked data.** It chooses bytes whose unsent upper bits would flip the parity. A design that counts all eight bits then sends the wrong parity.
- **Stick parity.** It chooses data whose computed parity differs from the stick value, so a design that ignores the stick bit shows up.
- **Break.** It sets break mid-character and checks that the line stays low through data and stop while the character still ends on time. A break that stalls or resets the shifter fails this.
- **Format changes.** It rewrites the format mid-character. A shifter that reads the control byte live changes length.
- **Back-to-back bytes and back-pressure.** It checks that the second byte waits with `in_ready` low, and that it starts the cycle the first stop period ends.
- **Missing ticks.** A stall of ticks must stretch the character by exactly the stall length.

// File: rtl/uart_fmt_pkg.sv
package uart_fmt_pkg;

  localparam int MAX_DW = 8;
  localparam int IDXW   = $clog2(MAX_DW);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef enum logic [1:0] {
    STOP_ONE      = 2'd0,
    STOP_ONE_HALF = 2'd1,
    STOP_TWO      = 2'd2
  } stop_sel_e;

  // low six bits of the control byte, MSB first
  typedef struct packed {
    logic       stick;
    logic       even;
    logic       par_en;
    logic       stop_long;
    logic [1:0] wlen;
  } fmt_ctl_t;

  // format captured with each character
  typedef struct packed {
    logic [IDXW-1:0] last_idx;
    logic            par_en;
    logic            par_bit;
    stop_sel_e       stop_sel;
  } frame_fmt_t;

endpackage

// File: rtl/uart_fmt_decode.sv
module uart_fmt_decode
  import uart_fmt_pkg::*;
(
  input  logic [5:0]        fmt_bits,
  input  logic [MAX_DW-1:0] data,
  output frame_fmt_t        fmt
);

  fmt_ctl_t          ctl;
  logic [MAX_DW-1:0] masked;
  logic              odd_ones;

  assign ctl = fmt_bits;

  // keep only the bits that will be sent
  always_comb begin
    masked = '0;
    for (int i = 0; i < MAX_DW; i++) begin
      if (i < 5 + int'(ctl.wlen)) masked[i] = data[i];
    end
  end

  assign odd_ones = ^masked;

  always_comb begin
    fmt.last_idx = IDXW'(4 + int'(ctl.wlen));
    fmt.par_en   = ctl.par_en;
    if (ctl.stick)     fmt.par_bit = ~ctl.even;
    else if (ctl.even) fmt.par_bit = odd_ones;
    else               fmt.par_bit = ~odd_ones;
    if (!ctl.stop_long)     fmt.stop_sel = STOP_ONE;
    else if (ctl.wlen == 0) fmt.stop_sel = STOP_ONE_HALF;
    else                    fmt.stop_sel = STOP_TWO;
  end

endmodule

// File: rtl/uart_fmt_hold.sv
module uart_fmt_hold
  import uart_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MAX_DW-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              take,
  output logic              full,
  output logic [MAX_DW-1:0] data_q
);

  logic full_q;
  logic accept;

  assign in_ready = ~full_q;
  assign accept   = in_valid & ~full_q;
  assign full     = full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (take) begin
      full_q <= 1'b0;
    end else if (accept) begin
      full_q <= 1'b1;
      data_q <= in_data;
    end
  end

  // a waiting byte is neither lost nor overwritten
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !take) |=> (full_q && $stable(data_q)));

  assert_accept_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

endmodule

// File: rtl/uart_fmt_shift.sv
module uart_fmt_shift
  import uart_fmt_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [MAX_DW-1:0] hold_data,
  input  frame_fmt_t        fmt,
  output logic              take,
  output logic              line,
  output logic              idle
);

  localparam int CW        = $clog2(2 * TICKS_PER_BIT + 1);
  localparam int HALF_BIT  = TICKS_PER_BIT / 2;

  tx_state_e         state;
  logic [MAX_DW-1:0] sh;
  logic [IDXW-1:0]   idx;
  logic [CW-1:0]     cnt;
  frame_fmt_t        fmt_q;
  logic [CW-1:0]     stop_limit;
  logic [CW-1:0]     limit;
  logic              phase_end;

  always_comb begin
    case (fmt_q.stop_sel)
      STOP_ONE_HALF: stop_limit = CW'(TICKS_PER_BIT + HALF_BIT);
      STOP_TWO:      stop_limit = CW'(2 * TICKS_PER_BIT);
      default:       stop_limit = CW'(TICKS_PER_BIT);
    endcase
  end

  assign limit     = (state == ST_STOP) ? stop_limit : CW'(TICKS_PER_BIT);
  assign phase_end = tick && (cnt == limit - 1'b1);
  assign take      = hold_full && ((state == ST_IDLE) || (state == ST_STOP && phase_end));
  assign idle      = (state == ST_IDLE);

  always_comb begin
    case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh[0];
      ST_PAR:   line = fmt_q.par_bit;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sh    <= '0;
      idx   <= '0;
      cnt   <= '0;
      fmt_q <= '0;
    end else if (take) begin
      state <= ST_START;
      sh    <= hold_data;
      fmt_q <= fmt;
      idx   <= '0;
      cnt   <= '0;
    end else if (state != ST_IDLE && tick) begin
      if (!phase_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (state)
          ST_START: begin
            state <= ST_DATA;
            idx   <= '0;
          end
          ST_DATA: begin
            sh <= sh >> 1;
            if (idx == fmt_q.last_idx) state <= fmt_q.par_en ? ST_PAR : ST_STOP;
            else                       idx   <= idx + 1'b1;
          end
          ST_PAR:  state <= ST_STOP;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (cnt < limit));

  assert_load_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (state == ST_START && cnt == '0));

  assert_fmt_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && !take) |=> $stable(fmt_q));

  assert_no_tick_freeze_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !take && state != ST_IDLE) |=> ($stable(cnt) && $stable(state)));

endmodule

// File: rtl/uart_fmt_tx.sv
module uart_fmt_tx
  import uart_fmt_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [7:0] lcr_i,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic       txd,
  output logic       hold_empty,
  output logic       tx_empty
);

  logic              hold_full;
  logic [MAX_DW-1:0] hold_data;
  logic              take;
  logic              line;
  logic              sh_idle;
  frame_fmt_t        fmt;
  logic              unused_ctl;

  assign unused_ctl = lcr_i[7];

  uart_fmt_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .take     (take),
    .full     (hold_full),
    .data_q   (hold_data)
  );

  uart_fmt_decode u_decode (
    .fmt_bits (lcr_i[5:0]),
    .data     (hold_data),
    .fmt      (fmt)
  );

  uart_fmt_shift #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .fmt       (fmt),
    .take      (take),
    .line      (line),
    .idle      (sh_idle)
  );

  // break acts on the pin only
  assign txd        = lcr_i[6] ? 1'b0 : line;
  assign hold_empty = ~hold_full;
  assign tx_empty   = sh_idle & ~hold_full;

  assert_idle_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !lcr_i[6]) |-> txd);

  assert_flag_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> hold_empty);

  assert_ready_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == hold_empty);

endmodule

// File: tb/uart_fmt_tx_bench.sv
module uart_fmt_tx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b1;
  logic [7:0] lcr_i = 8'h00;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready, txd, hold_empty, tx_empty;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_fmt_tx u_uart_fmt_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .lcr_i(lcr_i),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  // {control, data, data bits, parity on, parity bit, frame cycles}
  localparam logic [31:0] VECS [0:11] = '{
    {8'h00, 8'h15, 4'd5, 1'b0, 1'b0, 10'd112},
    {8'h04, 8'h0A, 4'd5, 1'b0, 1'b0, 10'd120},
    {8'h1B, 8'hA5, 4'd8, 1'b1, 1'b0, 10'd176},
    {8'h0B, 8'hA5, 4'd8, 1'b1, 1'b1, 10'd176},
    {8'h3B, 8'h01, 4'd8, 1'b1, 1'b0, 10'd176},
    {8'h2B, 8'h01, 4'd8, 1'b1, 1'b1, 10'd176},
    {8'h06, 8'hFF, 4'd7, 1'b0, 1'b0, 10'd160},
    {8'h0D, 8'h43, 4'd6, 1'b1, 1'b1, 10'd160},
    {8'h1E, 8'h80, 4'd7, 1'b1, 1'b0, 10'd176},
    {8'h21, 8'h3F, 4'd6, 1'b0, 1'b0, 10'd128},
    {8'h0F, 8'h00, 4'd8, 1'b1, 1'b1, 10'd192},
    {8'h1C, 8'h1F, 4'd5, 1'b1, 1'b1, 10'd136}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_frame(input logic [31:0] v, input int chg_at,
                           input logic [7:0] chg_lcr, input string extra);
    logic [7:0] l, d, rx, dmask;
    int nb, flen, got;
    logic pe, pb;
    l = v[31:24]; d = v[23:16]; nb = int'(v[15:12]); pe = v[11]; pb = v[10];
    flen = int'(v[9:0]);
    dmask = d & 8'((1 << nb) - 1);
    rx = '0;
    got = -1;
    lcr_i = l;
    send(d);
    for (int k = 0; k < 1000 && got < 0; k++) begin
      @(negedge clk);
      if (tx_empty) got = k;
      else begin
        if (k == 0) check(hold_empty == 1'b1, {"R7 hold empty once shifting", extra}, hold_empty, 1);
        if (k == 8) check(txd == 1'b0, {"R1 start bit", extra}, txd, 0);
        for (int i = 0; i < 8; i++)
          if (i < nb && k == 8 + 16 * (1 + i)) rx[i] = txd;
        if (k == 8 + 16 * (1 + nb)) begin
          if (!pe) check(txd == 1'b1, {"R3 no parity slot", extra}, txd, 1);
          else if (l[5]) check(txd == pb, {"R5 stick parity", extra}, txd, pb);
          else check(txd == pb, {"R4 parity sense", extra}, txd, pb);
        end
        if (k == flen - 8) check(txd == 1'b1, {"R2 stop level", extra}, txd, 1);
      end
      if (k == chg_at) lcr_i = chg_lcr;
    end
    check(rx == dmask, {"R1 data bits", extra}, rx, dmask);
    check(got == flen, {"R2 frame length", extra}, got, flen);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int got;
    logic [4:0] rx5;
    // R10 reset state
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R10 txd in reset", txd, 1);
    check(tx_empty == 1'b1, "R10 tx_empty in reset", tx_empty, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(txd == 1'b1, "R10 txd idle", txd, 1);
    check(hold_empty == 1'b1, "R10 hold_empty", hold_empty, 1);
    check(tx_empty == 1'b1, "R10 tx_empty", tx_empty, 1);
    check(in_ready == 1'b1, "R10 in_ready", in_ready, 1);

    // table walk
    for (int n = 0; n < 12; n++) run_frame(VECS[n], -1, 8'h00, "");

    // R9 format change mid-character
    run_frame(VECS[2], 20, 8'h00, " R9");

    // R6 break mid-character
    lcr_i = 8'h03;
    send(8'hFF);
    got = -1;
    for (int k = 0; k < 1000 && got < 0; k++) begin
      @(negedge clk);
      if (tx_empty) got = k;
      else begin
        if (k == 56)  check(txd == 1'b0, "R6 break over data", txd, 0);
        if (k == 152) check(txd == 1'b0, "R6 break over stop", txd, 0);
      end
      if (k == 30) lcr_i = 8'h43;
    end
    check(got == 160, "R6 timing kept under break", got, 160);
    lcr_i = 8'h03;
    @(negedge clk);
    check(txd == 1'b1, "R6 break released", txd, 1);

    // R8 back-pressure and back-to-back
    lcr_i = 8'h00;
    send(8'h15);
    check(in_ready == 1'b0, "R8 back-pressure", in_ready, 0);
    check(hold_empty == 1'b0, "R7 hold full", hold_empty, 0);
    in_valid = 1'b1;
    in_data  = 8'h0A;
    @(negedge clk);
    got = -1;
    rx5 = '0;
    for (int k = 1; k < 1000 && got < 0; k++) begin
      @(negedge clk);
      if (k == 1) begin
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R8 second byte held", in_ready, 0);
      end
      if (tx_empty) got = k;
      else begin
        if (k == 50) begin
          check(hold_empty == 1'b0, "R7 hold_empty while waiting", hold_empty, 0);
          check(tx_empty == 1'b0, "R7 tx_empty while busy", tx_empty, 0);
        end
        if (k == 115) check(hold_empty == 1'b1, "R7 hold drained", hold_empty, 1);
        if (k == 120) check(txd == 1'b0, "R8 no gap start", txd, 0);
        for (int i = 0; i < 5; i++)
          if (k == 120 + 16 * (1 + i)) rx5[i] = txd;
      end
    end
    check(rx5 == 5'h0A, "R8 second byte data", rx5, 5'h0A);
    check(got == 224, "R8 two frames length", got, 224);

    // R1 ticks gate progress
    lcr_i = 8'h00;
    send(8'h15);
    got = -1;
    for (int k = 0; k < 1000 && got < 0; k++) begin
      @(negedge clk);
      if (tx_empty) got = k;
      else if (k == 30) check(txd == 1'b0, "R1 start holds without ticks", txd, 0);
      if (k == 4)  baud_tick = 1'b0;
      if (k == 44) baud_tick = 1'b1;
    end
    check(got == 152, "R1 stall stretches frame", got, 152);

    // R10 reset mid-character
    lcr_i = 8'h03;
    send(8'h00);
    repeat (30) @(negedge clk);
    check(txd == 1'b0, "R10 busy before reset", txd, 0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1, "R10 txd after reset", txd, 1);
    check(tx_empty == 1'b1, "R10 tx_empty after reset", tx_empty, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule